// File: doc/BRIEF.md
# SDRAM Mode Register and Burst Column Sequencer

This block keeps the operating mode of a synchronous DRAM device and produces the column address for each beat of a burst. A mode-register-set strobe loads a 12-bit operation word. The word is decoded into a burst length, a beat ordering, a CAS latency and a write-length option. A word that carries any reserved code is refused. The block then raises an error flag and keeps the settings it already had.

A burst start supplies a starting column and a read/write flag. From the following cycle the block drives the column address for each beat and a valid flag, until the burst ends, is stopped or is replaced. A low clock enable freezes the whole block for that cycle. The column width is a parameter: 8 bits for the x16 organisation and 9 bits for the x8 organisation.

Top module: `sdram_burst_seq`

## Requirements
- R1: After a synchronous reset, `burst_vld` is 0 and `mode_err` is 0. The mode is burst length 1, sequential order, CAS latency 2 (`cas_lat` = 2, `ilv_mode` = 0), with writes using the programmed length.
- R2: A mode word with no reserved code, strobed while `cke` is high, takes effect on the next cycle and clears `mode_err`. The word is decoded as follows:
  - word[2:0] is the length code: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives a full page.
  - word[3] is the ordering: 1 is interleaved and 0 is sequential.
  - word[6:4] is the CAS latency: 010 gives 2 and 011 gives 3.
  - word[9] is the single-write option.
- R3: A mode word is refused if it has any of these: a length code of 100, 101 or 110; a length code of 111 together with word[3]=1; a latency code other than 010 or 011; word[8:7] not 00; or word[11:10] not 00. A refused word sets `mode_err` on the next cycle and leaves all settings unchanged.
- R4: A burst start makes `burst_vld` high and `col_out` equal to the start column on the next cycle. For a length of 1, 2, 4 or 8, `burst_vld` stays high for exactly that many cycles.
- R5: In sequential order, the low log2(length) column bits count up modulo the length from the start column, and the upper bits stay fixed.
- R6: In interleaved order, the low log2(length) column bits equal the start bits XOR the beat index, and the upper bits stay fixed.
- R7: A full-page burst steps through the whole column range, wrapping from the all-ones column to 0. It runs until it is stopped or replaced.
- R8: When single-write is set, a write burst has one beat. Reads use the programmed length. When single-write is clear, writes also use the programmed length.
- R9: A burst stop with no start in the same cycle drops `burst_vld` on the next cycle, and `col_out` holds its value.
- R10: A burst start during a burst abandons the old burst and restarts from the new column with a fresh beat count. A start takes priority over a stop in the same cycle.
- R11: When `cke` is low at a clock edge, every output and all internal state hold. Mode, start and stop strobes in that cycle are ignored.
- R12: A burst keeps the length and ordering that were in force at its start edge. A mode word written during the burst affects only later bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; low freezes the block |
| mrs_stb | input | 1 | Mode word load strobe |
| mrs_word | input | 12 | Operation word |
| start_stb | input | 1 | Burst start strobe |
| start_col | input | COL_W | Starting column |
| start_wr | input | 1 | 1 = write burst, 0 = read burst |
| stop_stb | input | 1 | Burst stop strobe |
| col_out | output | COL_W | Current column address |
| burst_vld | output | 1 | Column valid this cycle |
| mode_err | output | 1 | Last mode word was refused |
| cas_lat | output | 2 | Programmed CAS latency (2 or 3) |
| ilv_mode | output | 1 | Programmed ordering, 1 = interleaved |

## Verification
Some rules are checked on every cycle by the assertions:
- the freeze under a low clock enable;
- the first beat after a start;
- the drop of the valid flag after a stop;
- the error flag after a word with the reserved high bits set.

Other behaviour can only be shown by the bench's scenarios, which compare every cycle against an independent model:
- the beat order in sequential, interleaved and full-page bursts, including the wrap at the top of the column range;
- the exact burst length;
- the single-write shortening;
- isolation of a running burst from a mid-burst mode change.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef struct packed {
    logic [2:0] len_code;
    logic       ilv;
    logic [1:0] cas;
    logic       wr_single;
  } mode_t;

  localparam logic [2:0] LEN_FULL = 3'b111;

  localparam mode_t MODE_RESET = '{len_code: 3'b000, ilv: 1'b0,
                                   cas: 2'd2, wr_single: 1'b0};

  // A word is usable only if no field carries a reserved code.
  function automatic logic word_legal(input logic [11:0] w);
    logic len_ok, cas_ok;
    len_ok = (w[2] == 1'b0) || (w[2:0] == LEN_FULL && !w[3]);
    cas_ok = (w[6:4] == 3'b010) || (w[6:4] == 3'b011);
    return len_ok && cas_ok && (w[8:7] == 2'b00) && (w[11:10] == 2'b00);
  endfunction

endpackage

// File: rtl/sbs_mode_reg.sv
module sbs_mode_reg
  import sbs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cke,
  input  logic        mrs_stb,
  input  logic [11:0] mrs_word,
  output mode_t       mode,
  output logic        mode_err
);

  mode_t mode_q;
  logic  err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_RESET;
      err_q  <= 1'b0;
    end else if (cke && mrs_stb) begin
      if (word_legal(mrs_word)) begin
        mode_q.len_code  <= mrs_word[2:0];
        mode_q.ilv       <= mrs_word[3];
        mode_q.cas       <= (mrs_word[6:4] == 3'b011) ? 2'd3 : 2'd2;
        mode_q.wr_single <= mrs_word[9];
        err_q            <= 1'b0;
      end else begin
        err_q <= 1'b1;
      end
    end
  end

  assign mode     = mode_q;
  assign mode_err = err_q;

endmodule

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr
  import sbs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke,
  input  mode_t            mode,
  input  logic             start_stb,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_wr,
  input  logic             stop_stb,
  output logic [COL_W-1:0] col_out,
  output logic             burst_vld
);

  logic [COL_W-1:0] start_q, mask_q, beat_q, col_q;
  logic             ilv_q, full_q, vld_q;

  logic [COL_W-1:0] beat_nx, sum_nx, col_nx, mask_new;
  logic             last_beat, is_full;

  // Mask of column bits that move during the burst, chosen at start.
  always_comb begin
    is_full  = (mode.len_code == LEN_FULL) && !(start_wr && mode.wr_single);
    mask_new = '0;
    if (is_full) begin
      mask_new = '1;
    end else if (!(start_wr && mode.wr_single)) begin
      case (mode.len_code)
        3'b001:  mask_new = COL_W'(1);
        3'b010:  mask_new = COL_W'(3);
        3'b011:  mask_new = COL_W'(7);
        default: mask_new = '0;
      endcase
    end
  end

  assign beat_nx   = beat_q + COL_W'(1);
  assign sum_nx    = start_q + beat_nx;
  assign last_beat = !full_q && (beat_q == mask_q);

  // Per-bit selection: masked bits follow the ordering, others keep start.
  for (genvar i = 0; i < COL_W; i++) begin : g_col
    assign col_nx[i] = mask_q[i] ? (ilv_q ? (start_q[i] ^ beat_nx[i]) : sum_nx[i])
                                 : start_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      mask_q  <= '0;
      beat_q  <= '0;
      col_q   <= '0;
      ilv_q   <= 1'b0;
      full_q  <= 1'b0;
      vld_q   <= 1'b0;
    end else if (cke) begin
      if (start_stb) begin
        start_q <= start_col;
        col_q   <= start_col;
        mask_q  <= mask_new;
        full_q  <= is_full;
        ilv_q   <= mode.ilv;
        beat_q  <= '0;
        vld_q   <= 1'b1;
      end else if (stop_stb) begin
        vld_q <= 1'b0;
      end else if (vld_q) begin
        if (last_beat) begin
          vld_q <= 1'b0;
        end else begin
          beat_q <= beat_nx;
          col_q  <= col_nx;
        end
      end
    end
  end

  assign col_out   = col_q;
  assign burst_vld = vld_q;

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sbs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke,
  input  logic             mrs_stb,
  input  logic [11:0]      mrs_word,
  input  logic             start_stb,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_wr,
  input  logic             stop_stb,
  output logic [COL_W-1:0] col_out,
  output logic             burst_vld,
  output logic             mode_err,
  output logic [1:0]       cas_lat,
  output logic             ilv_mode
);

  mode_t mode;

  sbs_mode_reg u_mode (
    .clk      (clk),
    .rst      (rst),
    .cke      (cke),
    .mrs_stb  (mrs_stb),
    .mrs_word (mrs_word),
    .mode     (mode),
    .mode_err (mode_err)
  );

  sbs_burst_ctr #(.COL_W(COL_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .cke       (cke),
    .mode      (mode),
    .start_stb (start_stb),
    .start_col (start_col),
    .start_wr  (start_wr),
    .stop_stb  (stop_stb),
    .col_out   (col_out),
    .burst_vld (burst_vld)
  );

  assign cas_lat  = mode.cas;
  assign ilv_mode = mode.ilv;

endmodule

// File: rtl/sbs_chk.sv
module sbs_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cke,
  input logic             mrs_stb,
  input logic [11:0]      mrs_word,
  input logic             start_stb,
  input logic [COL_W-1:0] start_col,
  input logic             stop_stb,
  input logic [COL_W-1:0] col_out,
  input logic             burst_vld,
  input logic             mode_err,
  input logic [1:0]       cas_lat,
  input logic             ilv_mode
);

  // R11: a low clock enable freezes every output.
  a_r11_freeze: assert property (@(posedge clk) disable iff (rst)
    !cke |=> ($stable(col_out) && $stable(burst_vld) && $stable(mode_err)
              && $stable(cas_lat) && $stable(ilv_mode)));

  // R4: the first beat is the start column.
  a_r4_first_beat: assert property (@(posedge clk) disable iff (rst)
    (cke && start_stb) |=> (burst_vld && col_out == $past(start_col)));

  // R9: a stop ends the burst and holds the column.
  a_r9_stop: assert property (@(posedge clk) disable iff (rst)
    (cke && stop_stb && !start_stb) |=> (!burst_vld && $stable(col_out)));

  // R3: reserved high bits always refuse the word.
  a_r3_high_bits: assert property (@(posedge clk) disable iff (rst)
    (cke && mrs_stb && mrs_word[11:10] != 2'b00) |=> mode_err);

  // R2: the latency output only ever holds a legal value.
  a_r2_cas_range: assert property (@(posedge clk) disable iff (rst)
    (cas_lat == 2'd2) || (cas_lat == 2'd3));

endmodule

bind sdram_burst_seq sbs_chk #(.COL_W(COL_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cke       (cke),
  .mrs_stb   (mrs_stb),
  .mrs_word  (mrs_word),
  .start_stb (start_stb),
  .start_col (start_col),
  .stop_stb  (stop_stb),
  .col_out   (col_out),
  .burst_vld (burst_vld),
  .mode_err  (mode_err),
  .cas_lat   (cas_lat),
  .ilv_mode  (ilv_mode)
);

// File: tb/sdram_burst_seq_tb_top.sv
module sdram_burst_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int COL_W      = 8;
  localparam int NCOL       = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cke = 1'b1;
  logic             mrs_stb = 1'b0;
  logic [11:0]      mrs_word = '0;
  logic             start_stb = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic             start_wr = 1'b0;
  logic             stop_stb = 1'b0;
  logic [COL_W-1:0] col_out;
  logic             burst_vld, mode_err, ilv_mode;
  logic [1:0]       cas_lat;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_burst_seq #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst(rst), .cke(cke), .mrs_stb(mrs_stb), .mrs_word(mrs_word),
    .start_stb(start_stb), .start_col(start_col), .start_wr(start_wr),
    .stop_stb(stop_stb), .col_out(col_out), .burst_vld(burst_vld),
    .mode_err(mode_err), .cas_lat(cas_lat), .ilv_mode(ilv_mode)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_tag = "R1";

  // Reference model state
  int m_len, m_ilv, m_cas, m_wsingle, m_err;
  int m_vld, m_col, m_start, m_beat, m_blen, m_bilv;

  function automatic bit ref_legal(input logic [11:0] w);
    bit ok = 1;
    if (w[2:0] inside {3'd4, 3'd5, 3'd6}) ok = 0;
    if (w[2:0] == 3'd7 && w[3]) ok = 0;
    if (!(w[6:4] inside {3'd2, 3'd3})) ok = 0;
    if (w[8:7] != 0 || w[11:10] != 0) ok = 0;
    return ok;
  endfunction

  function automatic int ref_col(input int st, input int beat, input int blen, input int il);
    int base, off;
    if (blen == 0) return (st + beat) % NCOL;
    base = st - (st % blen);
    off  = st % blen;
    if (il != 0) return base + (off ^ beat);
    return base + ((off + beat) % blen);
  endfunction

  task automatic model_step();
    int old_len, old_ilv, old_ws;
    if (rst) begin
      m_len = 0; m_ilv = 0; m_cas = 2; m_wsingle = 0; m_err = 0;
      m_vld = 0; m_col = 0; m_start = 0; m_beat = 0; m_blen = 1; m_bilv = 0;
      return;
    end
    if (!cke) return;
    old_len = m_len; old_ilv = m_ilv; old_ws = m_wsingle;
    if (mrs_stb) begin
      if (ref_legal(mrs_word)) begin
        m_len = int'(mrs_word[2:0]); m_ilv = int'(mrs_word[3]);
        m_cas = (mrs_word[6:4] == 3'd3) ? 3 : 2;
        m_wsingle = int'(mrs_word[9]); m_err = 0;
      end else m_err = 1;
    end
    if (start_stb) begin
      if (start_wr && old_ws != 0) m_blen = 1;
      else if (old_len == 7)       m_blen = 0;
      else                         m_blen = 1 << old_len;
      m_bilv = old_ilv; m_start = int'(start_col); m_beat = 0;
      m_col = m_start; m_vld = 1;
    end else if (stop_stb) begin
      m_vld = 0;
    end else if (m_vld != 0) begin
      if (m_blen != 0 && m_beat == m_blen - 1) m_vld = 0;
      else begin
        m_beat++;
        m_col = ref_col(m_start, m_beat, m_blen, m_bilv);
      end
    end
  endtask

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("burst_vld", int'(burst_vld), m_vld);
    chk("mode_err", int'(mode_err), m_err);
    chk("cas_lat", int'(cas_lat), m_cas);
    chk("ilv_mode", int'(ilv_mode), m_ilv);
    if (m_vld != 0) chk("col_out", int'(col_out), m_col);
  endtask

  // One clock: model follows the edge, outputs sampled at the falling edge.
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    mrs_stb = 0; start_stb = 0; stop_stb = 0; cke = 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic set_mode(input logic [11:0] w);
    mrs_stb = 1; mrs_word = w; cyc();
  endtask

  task automatic go(input logic [COL_W-1:0] c, input logic wr);
    start_stb = 1; start_col = c; start_wr = wr; cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    cur_tag = "R1";
    idle(3);
    rst = 0;
    idle(2);

    cur_tag = "R2";                 // BL4, interleaved, CL3
    set_mode(12'h03A); idle(1);
    cur_tag = "R3";
    set_mode(12'h43A); idle(1);     // bit 10 set
    set_mode(12'h024); idle(1);     // length code 100
    set_mode(12'h02F); idle(1);     // full page + interleaved
    set_mode(12'h04A); idle(1);     // latency 100
    set_mode(12'h0A2); idle(1);     // bit 7 set
    cur_tag = "R6";
    set_mode(12'h03A);
    go(8'h05, 0); idle(5);

    cur_tag = "R5";                 // BL8 sequential CL2
    set_mode(12'h023);
    go(8'h1D, 0); idle(9);
    cur_tag = "R4";                 // BL2, then BL1
    set_mode(12'h021);
    go(8'h11, 0); idle(3);
    set_mode(12'h020);
    go(8'h42, 1); idle(2);

    cur_tag = "R7";                 // full page, wrap at top
    set_mode(12'h027);
    go(8'hFE, 0); idle(12);
    cur_tag = "R9";
    stop_stb = 1; cyc(); idle(2);

    cur_tag = "R8";                 // single write, BL4 sequential
    set_mode(12'h222);
    go(8'h33, 1); idle(2);
    go(8'h33, 0); idle(5);
    set_mode(12'h022);
    go(8'h36, 1); idle(5);

    cur_tag = "R10";
    set_mode(12'h023);
    go(8'h80, 0); idle(2);
    go(8'h47, 0); idle(2);
    start_stb = 1; stop_stb = 1; start_col = 8'h90; start_wr = 0; cyc();
    idle(9);

    cur_tag = "R11";
    go(8'h60, 0); idle(1);
    cke = 0; mrs_stb = 1; mrs_word = 12'h03A; cyc();
    cke = 0; start_stb = 1; start_col = 8'h01; cyc();
    cke = 0; stop_stb = 1; cyc();
    idle(8);

    cur_tag = "R12";
    go(8'h20, 0); idle(1);
    set_mode(12'h03A); idle(8);

    cur_tag = "R5";                 // random mix across all features
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 99));
      logic [11:0] legal_w [6];
      legal_w[0] = 12'h020; legal_w[1] = 12'h031; legal_w[2] = 12'h03A;
      legal_w[3] = 12'h02B; legal_w[4] = 12'h027; legal_w[5] = 12'h232;
      cke = ($urandom_range(0, 7) != 0);
      if (r < 6) begin
        mrs_stb = 1;
        mrs_word = (r < 5) ? legal_w[$urandom_range(0, 5)] : 12'($urandom());
      end
      if (r >= 10 && r < 26) begin
        start_stb = 1; start_col = COL_W'($urandom()); start_wr = 1'($urandom());
      end
      if (r >= 90 && r < 94) stop_stb = 1;
      cyc();
    end

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule